// File: doc/BRIEF.md
# Integer ALU with Status Flags and Condition Test

This block is the execute-stage arithmetic unit of a simple 32-bit processor pipeline. It combines two source operands under a small function code (add, subtract, bitwise AND, bitwise XOR) and produces a combinational result. When the instruction being executed is an arithmetic or logic operation, the pipeline raises the flag-load enable. On the next rising clock edge, the zero, sign and signed-overflow status of that result is captured in a three-bit flag register.

A separate condition selector reads only the registered flags and answers whether a given condition holds. Conditional branches and conditional register moves use this same answer. Code 0 always holds, which is how an unconditional jump or a plain register copy is expressed. Subtraction takes the first operand away from the second (B minus A), matching a two-register instruction whose destination is the second register.

Top module: `alu_cc_unit`

## Requirements
- R1: With function code 0, `result` equals `opb + opa` modulo 2^32, combinationally.
- R2: With function code 1, `result` equals `opb - opa` modulo 2^32.
- R3: Function code 2 gives `opa & opb`, code 3 gives `opa ^ opb`, and any code from 4 to 15 gives a result of zero.
- R4: On a rising edge with `set_cc` high, `zf` becomes 1 exactly when `result` was zero, and `sf` becomes bit 31 of `result`.
- R5: On the same edge, `of` becomes 1 for add or subtract exactly when the signed two's-complement result does not fit in 32 bits. For every other function code it becomes 0.
- R6: On a rising edge with `set_cc` low, `zf`, `sf` and `of` keep their values, whatever the operands and function code are.
- R7: While `rst_n` is low, the flags are `zf`=1, `sf`=0, `of`=0.
- R8: `cond_true` is 1 for condition code 0 (always), equals `zf` for code 3 (equal), and equals NOT `zf` for code 4 (not equal).
- R9: For condition code 2 (less), `cond_true` is `sf ^ of`. For code 1 (less or equal) it is `(sf ^ of) | zf`. For code 5 (greater or equal) it is `~(sf ^ of)`. For code 6 (greater) it is `~(sf ^ of) & ~zf`.
- R10: Condition codes 7 to 15 give `cond_true` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa | input | 32 | Operand A (subtrahend for subtract) |
| opb | input | 32 | Operand B (minuend for subtract) |
| alu_fn | input | 4 | Operation select: 0 add, 1 subtract, 2 AND, 3 XOR |
| set_cc | input | 1 | Load the flag register on the next rising edge |
| cond_fn | input | 4 | Condition select, codes 0 to 6 defined |
| result | output | 32 | Combinational ALU result |
| zf | output | 1 | Registered zero flag |
| sf | output | 1 | Registered sign flag |
| of | output | 1 | Registered signed-overflow flag |
| cond_true | output | 1 | Selected condition evaluated on the registered flags |

## Verification
On every cycle, the embedded properties check that the flags capture the zero and sign status of the previous result under `set_cc` and stay frozen without it. They also check that logic operations never leave overflow set, that code 0 is always true, and that undefined condition codes are never true. The exact arithmetic values and the overflow decision at the signed limits are shown only by the bench. It sweeps corner operands (zero, ±1, the most positive and most negative numbers) through every function code and then tests all sixteen condition codes against each resulting flag state.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
   localparam int FN_ADD = 0;
   localparam int FN_SUB = 1;
   localparam int FN_AND = 2;
   localparam int FN_XOR = 3;

   localparam int CC_ALWAYS = 0;
   localparam int CC_LE     = 1;
   localparam int CC_LT     = 2;
   localparam int CC_EQ     = 3;
   localparam int CC_NE     = 4;
   localparam int CC_GE     = 5;
   localparam int CC_GT     = 6;

   typedef struct packed {
      logic z;
      logic s;
      logic o;
   } flags_t;
endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
   import alu_cc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int FN_W      = 4,
   parameter int OVF_STYLE = 0   // 0: operand/result signs, 1: carry into vs out of MSB
) (
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [FN_W-1:0]   alu_fn,
   output logic [DATA_W-1:0] result,
   output flags_t            next_flags
);
   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("alu_datapath: DATA_W must be at least 2");
      end
      if (FN_W < 2) begin : g_bad_fn
         $error("alu_datapath: FN_W must be at least 2");
      end
      if (OVF_STYLE != 0 && OVF_STYLE != 1) begin : g_bad_style
         $error("alu_datapath: OVF_STYLE must be 0 or 1");
      end
   endgenerate

   logic              is_sub;
   logic              is_arith;
   logic [DATA_W-1:0] addend;
   logic [DATA_W-1:0] sum;
   logic              ovf_arith;

   assign is_sub   = (alu_fn == FN_W'(FN_SUB));
   assign is_arith = (alu_fn == FN_W'(FN_ADD)) || is_sub;
   // subtract is opb + ~opa + 1
   assign addend   = is_sub ? ~opa : opa;

   generate
      if (OVF_STYLE == 0) begin : g_ovf_sign
         assign sum       = opb + addend + DATA_W'(is_sub);
         assign ovf_arith = (opb[MSB] == addend[MSB]) && (sum[MSB] != opb[MSB]);
      end else begin : g_ovf_carry
         logic [DATA_W:0] wide;
         logic            c_in_msb;
         assign wide      = {1'b0, opb} + {1'b0, addend} + (DATA_W + 1)'(is_sub);
         assign sum       = wide[MSB:0];
         assign c_in_msb  = opb[MSB] ^ addend[MSB] ^ sum[MSB];
         assign ovf_arith = c_in_msb ^ wide[DATA_W];
      end
   endgenerate

   always_comb begin
      unique case (alu_fn)
         FN_W'(FN_ADD),
         FN_W'(FN_SUB): result = sum;
         FN_W'(FN_AND): result = opa & opb;
         FN_W'(FN_XOR): result = opa ^ opb;
         default:       result = '0;
      endcase
   end

   assign next_flags.z = (result == '0);
   assign next_flags.s = result[MSB];
   assign next_flags.o = is_arith & ovf_arith;
endmodule

// File: rtl/flag_store.sv
module flag_store
   import alu_cc_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   load,
   input  flags_t d,
   output flags_t q
);
   localparam flags_t RESET_FLAGS = '{z: 1'b1, s: 1'b0, o: 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RESET_FLAGS;
      end else if (load) begin
         q <= d;
      end
   end

   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> q == $past(q)); // R6
endmodule

// File: rtl/cond_select.sv
module cond_select
   import alu_cc_pkg::*;
#(
   parameter int CC_W = 4
) (
   input  flags_t          flags,
   input  logic [CC_W-1:0] cond_fn,
   output logic            hit
);
   generate
      if (CC_W < 3) begin : g_bad_cc
         $error("cond_select: CC_W must be at least 3");
      end
   endgenerate

   logic lt;
   assign lt = flags.s ^ flags.o;

   always_comb begin
      unique case (cond_fn)
         CC_W'(CC_ALWAYS): hit = 1'b1;
         CC_W'(CC_LE):     hit = lt | flags.z;
         CC_W'(CC_LT):     hit = lt;
         CC_W'(CC_EQ):     hit = flags.z;
         CC_W'(CC_NE):     hit = ~flags.z;
         CC_W'(CC_GE):     hit = ~lt;
         CC_W'(CC_GT):     hit = ~lt & ~flags.z;
         default:          hit = 1'b0;
      endcase
   end

   always_comb begin
      AST_EQ_NE_EXCLUSIVE: assert (!(cond_fn == CC_W'(CC_EQ) && hit && !flags.z)); // R8
   end
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
   import alu_cc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int FN_W      = 4,
   parameter int CC_W      = 4,
   parameter int OVF_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [FN_W-1:0]   alu_fn,
   input  logic              set_cc,
   input  logic [CC_W-1:0]   cond_fn,
   output logic [DATA_W-1:0] result,
   output logic              zf,
   output logic              sf,
   output logic              of,
   output logic              cond_true
);
   flags_t nxt_flags;
   flags_t cur_flags;

   alu_datapath #(
      .DATA_W   (DATA_W),
      .FN_W     (FN_W),
      .OVF_STYLE(OVF_STYLE)
   ) u_dp (
      .opa       (opa),
      .opb       (opb),
      .alu_fn    (alu_fn),
      .result    (result),
      .next_flags(nxt_flags)
   );

   flag_store u_flags (
      .clk  (clk),
      .rst_n(rst_n),
      .load (set_cc),
      .d    (nxt_flags),
      .q    (cur_flags)
   );

   cond_select #(.CC_W(CC_W)) u_cond (
      .flags  (cur_flags),
      .cond_fn(cond_fn),
      .hit    (cond_true)
   );

   assign zf = cur_flags.z;
   assign sf = cur_flags.s;
   assign of = cur_flags.o;

   AST_ZERO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      set_cc |=> zf == ($past(result) == '0)); // R4
   AST_SIGN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      set_cc |=> sf == $past(result[DATA_W-1])); // R4
   AST_NO_OVF_LOGIC: assert property (@(posedge clk) disable iff (!rst_n)
      (set_cc && alu_fn != FN_W'(FN_ADD) && alu_fn != FN_W'(FN_SUB)) |=> !of); // R5
   AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_fn == CC_W'(CC_ALWAYS)) |-> cond_true); // R8
   AST_UNDEF_COND: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_fn > CC_W'(CC_GT)) |-> !cond_true); // R10
endmodule

// File: tb/sim_alu_cc_unit.sv
`timescale 1ns/1ps
module sim_alu_cc_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] opa = '0, opb = '0;
   logic [3:0]  alu_fn = '0;
   logic        set_cc = 1'b0;
   logic [3:0]  cond_fn = '0;
   logic [31:0] result;
   logic        zf, sf, of, cond_true;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   alu_cc_unit u0 (
      .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .alu_fn(alu_fn),
      .set_cc(set_cc), .cond_fn(cond_fn), .result(result),
      .zf(zf), .sf(sf), .of(of), .cond_true(cond_true)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (a=%h b=%h fn=%0d cc=%0d)",
                  req, act, exp, opa, opb, alu_fn, cond_fn);
      end
   endtask

   function automatic logic [31:0] pick(input int k);
      case (k)
         0: return 32'h0000_0000;
         1: return 32'h0000_0001;
         2: return 32'hFFFF_FFFF;
         3: return 32'h7FFF_FFFF;
         4: return 32'h8000_0000;
         5: return 32'h0000_0005;
         6: return 32'h1234_5678;
         default: return 32'hF0F0_1234;
      endcase
   endfunction

   function automatic logic [31:0] model_res(input logic [31:0] a, input logic [31:0] b, input int f);
      case (f)
         0: return b + a;
         1: return b - a;
         2: return a & b;
         3: return a ^ b;
         default: return 32'h0;
      endcase
   endfunction

   function automatic bit model_ovf(input logic [31:0] a, input logic [31:0] b, input int f);
      logic signed [33:0] wide;
      if (f == 0) wide = $signed({{2{b[31]}}, b}) + $signed({{2{a[31]}}, a});
      else if (f == 1) wide = $signed({{2{b[31]}}, b}) - $signed({{2{a[31]}}, a});
      else return 1'b0;
      return (wide > 34'sd2147483647) || (wide < -34'sd2147483648);
   endfunction

   function automatic bit model_cond(input int c, input bit z, input bit s, input bit o);
      bit lt = s ^ o;
      case (c)
         0: return 1'b1;
         1: return lt | z;
         2: return lt;
         3: return z;
         4: return !z;
         5: return !lt;
         6: return !lt && !z;
         default: return 1'b0;
      endcase
   endfunction

   task automatic sweep_conds(input bit z, input bit s, input bit o);
      for (int c = 0; c < 16; c++) begin
         cond_fn = 4'(c);
         #1;
         check(cond_true == model_cond(c, z, s, o),
               (c == 0 || c == 3 || c == 4) ? "R8" : (c <= 6 ? "R9" : "R10"),
               32'(cond_true), 32'(model_cond(c, z, s, o)));
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] er;
      bit ez, es, eo;
      // R7 reset state
      @(negedge clk);
      @(negedge clk);
      check({zf, sf, of} == 3'b100, "R7", 32'({zf, sf, of}), 32'b100);
      sweep_conds(1'b1, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 8; j++) begin
            for (int f = 0; f < 6; f++) begin
               int fc = (f < 4) ? f : (f == 4 ? 4 + i : 8 + j);
               opa = pick(i); opb = pick(j); alu_fn = 4'(fc); set_cc = 1'b1;
               #1;
               er = model_res(opa, opb, fc);
               check(result == er, fc == 0 ? "R1" : (fc == 1 ? "R2" : "R3"), result, er);
               ez = (er == 0); es = er[31]; eo = model_ovf(opa, opb, fc);
               @(negedge clk);
               set_cc = 1'b0;
               check(zf == ez && sf == es, "R4", 32'({zf, sf}), 32'({ez, es}));
               check(of == eo, "R5", 32'(of), 32'(eo));
               if (f < 4) sweep_conds(ez, es, eo);
               // R6: different stimulus with set_cc low must not move flags
               opa = ~opa; opb = opb + 32'h1; alu_fn = 4'(f ^ 1);
               @(negedge clk);
               @(negedge clk);
               check({zf, sf, of} == {ez, es, eo}, "R6", 32'({zf, sf, of}), 32'({ez, es, eo}));
            end
         end
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule